// File: doc/BRIEF.md
# Access Permission Checker with Fault Registers

This block decides, in the same cycle an access is presented, whether a translated access may proceed. It takes the 3-bit access field and the modified bit of the final translation entry, the kind of access (read, write or instruction fetch), the privilege level, a no-fault mode bit and any error that the table walk reported. It returns an allowed flag and a protection mask of read, write and execute rights that a translation cache may store with the entry.

A denied access is written into a 10-bit fault status register, and its page-aligned virtual address is written into a fault address register. Software reads the status through a read strobe. The strobe clears the register on the following edge. A second fault that arrives before software has read the first one sets an overflow bit.

Top module: `access_guard`

## Requirements
- R1: On a recorded fault the status word is laid out as bits [9:8] walk level, [7:5] access index {write, fetch, supervisor}, [4:2] fault type, bit 1 set to 1 (address valid) and bit 0 the overflow flag. Kind encoding: 0 read, 1 write, 2 fetch.
- R2: When there is no walk error, the fault type is 3 (privilege) for a user access to field 6 or 7. Otherwise it is 2 (protection) when the right the access kind needs is missing from the supervisor-or-user rights of R3, and 0 when the right is present. A read needs r, a write needs w and a fetch needs x.
- R3: Rights by field, where permMask bit 0 is r, bit 1 is w and bit 2 is x. Field 0 gives r. Field 1 gives rw. Field 2 gives rx. Field 3 gives rwx. Field 4 gives x. Field 5 gives r to a user and rw to the supervisor. Field 6 gives nothing to a user and rx to the supervisor. Field 7 gives nothing to a user and rwx to the supervisor. permMask carries these rights whenever allowed is 1 and is 0 otherwise.
- R4: While the entry's modified bit is 0, permMask bit 1 is 0.
- R5: With no-fault mode set, a user access that has a nonzero fault type and no walk error is allowed, and the status is not updated.
- R6: A walk error denies the access with permMask 0. The status then takes the walk level and fault type 1 (entry invalid) or 4 (reserved entry). This happens even in no-fault mode.
- R7: A fault that arrives while the status is nonzero and no read strobe is active leaves only the overflow bit 0 from the old value, then ORs in the new fault word.
- R8: The status stays visible during a read-strobe cycle and is 0 after that edge when no fault arrives in the same cycle.
- R9: A fault in the same cycle as a read strobe is recorded with bit 0 clear.
- R10: On a fault, faultAddr is loaded with reqVa with its low PAGE_SHIFT bits cleared. Without a fault it keeps its value.
- R11: After reset, faultStatus and faultAddr are 0.
- R12: With reqValid low the block reports allowed 0 and permMask 0, and neither register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | An access is presented this cycle |
| reqVa | input | VA_W | Virtual address of the access |
| reqKind | input | 2 | 0 read, 1 write, 2 fetch (3 acts as read) |
| reqSuper | input | 1 | Access is from supervisor mode |
| noFaultMode | input | 1 | Suppresses check faults for user accesses |
| leafAcc | input | 3 | Access field of the final entry |
| leafModified | input | 1 | Modified bit of the final entry |
| walkErr | input | 1 | The table walk failed |
| walkErrLevel | input | 2 | Level at which the walk failed |
| walkErrReserved | input | 1 | 1 for a reserved entry, 0 for an invalid entry |
| statusRd | input | 1 | Software read strobe for the status register |
| allowed | output | 1 | The access may proceed |
| permMask | output | 3 | Granted rights {x, w, r} |
| faultStatus | output | 10 | Fault status register |
| faultAddr | output | VA_W | Fault address register |

## Verification
On every cycle the assertions check the register side: a fault sets the address-valid bit and loads the aligned address, a read strobe without a fault clears the status, overflow is set or held back as R7 and R9 require, permMask obeys the modified bit and the idle and walk-error cases, and no-fault user accesses pass. The full table of rights and fault types under R2 and R3 can only be shown by the bench's sweep over every kind, privilege level, no-fault setting, field and modified bit. The same holds for the exact status words, including walk levels, that arise from those combinations.

// File: rtl/ag_pkg.sv
package ag_pkg;
  localparam int STATUS_W = 10;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } accKind_t;

  typedef enum logic [2:0] {
    FT_NONE     = 3'd0,
    FT_INVALID  = 3'd1,
    FT_PROT     = 3'd2,
    FT_PRIV     = 3'd3,
    FT_RESERVED = 3'd4
  } faultType_t;

  // bit 0 = read, bit 1 = write, bit 2 = execute
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;

  typedef struct packed {
    logic record;
    logic overflow;
    logic clear;
  } statusStrobe_t;
endpackage

// File: rtl/ag_rights.sv
module ag_rights
  import ag_pkg::*;
(
  input  logic [2:0] field,
  input  logic       isSuper,
  input  accKind_t   kind,
  input  logic       modified,
  output rights_t    grant,
  output faultType_t checkCode
);
  rights_t base;
  logic    needMet;

  always_comb begin
    base = '0;
    unique case (field)
      3'd0: base = '{x: 1'b0, w: 1'b0, r: 1'b1};
      3'd1: base = '{x: 1'b0, w: 1'b1, r: 1'b1};
      3'd2: base = '{x: 1'b1, w: 1'b0, r: 1'b1};
      3'd3: base = '{x: 1'b1, w: 1'b1, r: 1'b1};
      3'd4: base = '{x: 1'b1, w: 1'b0, r: 1'b0};
      3'd5: base = '{x: 1'b0, w: isSuper, r: 1'b1};
      3'd6: base = '{x: isSuper, w: 1'b0, r: isSuper};
      3'd7: base = '{x: isSuper, w: isSuper, r: isSuper};
      default: base = '0;
    endcase
  end

  always_comb begin
    unique case (kind)
      KIND_WRITE: needMet = base.w;
      KIND_FETCH: needMet = base.x;
      default:    needMet = base.r;
    endcase
  end

  always_comb begin
    if (!isSuper && (field[2:1] == 2'b11)) checkCode = FT_PRIV;
    else if (!needMet)                     checkCode = FT_PROT;
    else                                   checkCode = FT_NONE;
  end

  always_comb begin
    grant   = base;
    grant.w = base.w & modified;
  end
endmodule

// File: rtl/ag_ctrl.sv
module ag_ctrl
  import ag_pkg::*;
(
  input  logic                reqValid,
  input  accKind_t            kind,
  input  logic                isSuper,
  input  logic                noFaultMode,
  input  faultType_t          checkCode,
  input  rights_t             grantIn,
  input  logic                walkErr,
  input  logic [1:0]          walkErrLevel,
  input  logic                walkErrReserved,
  input  logic                statusRd,
  input  logic                statusNonZero,
  output logic                allowed,
  output rights_t             permOut,
  output statusStrobe_t       strobe,
  output logic [STATUS_W-1:0] faultWord
);
  logic       checkFault;
  logic       fault;
  logic [2:0] accIdx;
  faultType_t faultType;
  logic [1:0] level;

  assign checkFault = (checkCode != FT_NONE) && !(noFaultMode && !isSuper);
  assign fault      = reqValid && (walkErr || checkFault);
  assign accIdx     = {kind == KIND_WRITE, kind == KIND_FETCH, isSuper};
  assign faultType  = walkErr ? (walkErrReserved ? FT_RESERVED : FT_INVALID) : checkCode;
  assign level      = walkErr ? walkErrLevel : 2'd0;
  assign faultWord  = {level, accIdx, faultType, 1'b1, 1'b0};

  assign allowed = reqValid && !fault;
  assign permOut = allowed ? grantIn : '0;

  assign strobe.record   = fault;
  assign strobe.overflow = fault && statusNonZero && !statusRd;
  assign strobe.clear    = statusRd && !fault;
endmodule

// File: rtl/ag_datapath.sv
module ag_datapath
  import ag_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  statusStrobe_t       strobe,
  input  logic [STATUS_W-1:0] faultWord,
  input  logic [VA_W-1:0]     reqVa,
  output logic [STATUS_W-1:0] statusQ,
  output logic [VA_W-1:0]     addrQ,
  output logic                statusNonZero
);
  localparam int PAGE_HI = VA_W - PAGE_SHIFT;

  logic [VA_W-1:0] alignedVa;
  assign alignedVa     = {reqVa[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign statusNonZero = |statusQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
    end else if (strobe.record) begin
      statusQ <= faultWord | {{(STATUS_W-1){1'b0}}, strobe.overflow};
    end else if (strobe.clear) begin
      statusQ <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              addrQ <= '0;
    else if (strobe.record) addrQ <= alignedVa;
  end

  initial begin
    if (PAGE_HI < 1) $error("PAGE_SHIFT must be below VA_W");
  end
endmodule

// File: rtl/access_guard.sv
module access_guard
  import ag_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [VA_W-1:0]     reqVa,
  input  logic [1:0]          reqKind,
  input  logic                reqSuper,
  input  logic                noFaultMode,
  input  logic [2:0]          leafAcc,
  input  logic                leafModified,
  input  logic                walkErr,
  input  logic [1:0]          walkErrLevel,
  input  logic                walkErrReserved,
  input  logic                statusRd,
  output logic                allowed,
  output logic [2:0]          permMask,
  output logic [STATUS_W-1:0] faultStatus,
  output logic [VA_W-1:0]     faultAddr
);
  accKind_t            kind;
  rights_t             grant;
  rights_t             permOut;
  faultType_t          checkCode;
  statusStrobe_t       strobe;
  logic [STATUS_W-1:0] faultWord;
  logic                statusNonZero;

  assign kind     = accKind_t'(reqKind);
  assign permMask = permOut;

  ag_rights rights_i (
    .field(leafAcc), .isSuper(reqSuper), .kind(kind),
    .modified(leafModified), .grant(grant), .checkCode(checkCode)
  );

  ag_ctrl ctrl_i (
    .reqValid(reqValid), .kind(kind), .isSuper(reqSuper),
    .noFaultMode(noFaultMode), .checkCode(checkCode), .grantIn(grant),
    .walkErr(walkErr), .walkErrLevel(walkErrLevel),
    .walkErrReserved(walkErrReserved), .statusRd(statusRd),
    .statusNonZero(statusNonZero), .allowed(allowed), .permOut(permOut),
    .strobe(strobe), .faultWord(faultWord)
  );

  ag_datapath #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .faultWord(faultWord),
    .reqVa(reqVa), .statusQ(faultStatus), .addrQ(faultAddr),
    .statusNonZero(statusNonZero)
  );
endmodule

// File: rtl/ag_checker.sv
module ag_checker #(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [VA_W-1:0] reqVa,
  input logic            reqSuper,
  input logic            noFaultMode,
  input logic            leafModified,
  input logic            walkErr,
  input logic            statusRd,
  input logic            allowed,
  input logic [2:0]      permMask,
  input logic [9:0]      faultStatus,
  input logic [VA_W-1:0] faultAddr
);
  logic faultNow;
  assign faultNow = reqValid && !allowed;

  assert_valid_bit_R1: assert property (@(posedge clk) disable iff (!rstN)
    faultNow |=> faultStatus[1]);

  assert_nofault_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && noFaultMode && !reqSuper && !walkErr) |-> allowed);

  assert_walk_deny_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && walkErr) |-> (!allowed && permMask == 3'b000));

  assert_write_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    !leafModified |-> !permMask[1]);

  assert_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (faultNow && !statusRd && faultStatus != 10'd0) |=> faultStatus[0]);

  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !faultNow) |=> faultStatus == 10'd0);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (faultNow && statusRd) |=> !faultStatus[0]);

  assert_addr_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    faultNow |=> (faultAddr >> PAGE_SHIFT) == ($past(reqVa) >> PAGE_SHIFT)
                 && (faultAddr << (VA_W - PAGE_SHIFT)) == '0);

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !faultNow |=> $stable(faultAddr));

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!allowed && permMask == 3'b000));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && !statusRd) |=> $stable(faultStatus));
endmodule

bind access_guard ag_checker #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa),
  .reqSuper(reqSuper), .noFaultMode(noFaultMode), .leafModified(leafModified),
  .walkErr(walkErr), .statusRd(statusRd), .allowed(allowed),
  .permMask(permMask), .faultStatus(faultStatus), .faultAddr(faultAddr)
);

// File: tb/access_guard_tb.sv
module access_guard_tb_top;
  localparam int VA_W = 32;
  localparam int PAGE_SHIFT = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [VA_W-1:0] reqVa = '0;
  logic [1:0] reqKind = 2'd0;
  logic reqSuper = 1'b0, noFaultMode = 1'b0;
  logic [2:0] leafAcc = 3'd0;
  logic leafModified = 1'b0;
  logic walkErr = 1'b0;
  logic [1:0] walkErrLevel = 2'd0;
  logic walkErrReserved = 1'b0;
  logic statusRd = 1'b0;
  logic allowed;
  logic [2:0] permMask;
  logic [9:0] faultStatus;
  logic [VA_W-1:0] faultAddr;

  int checks = 0;
  int errors = 0;
  logic [VA_W-1:0] expAddr = '0;

  always #5 clk = ~clk;

  access_guard #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [2:0] model_rights(input logic [2:0] f, input bit sup);
    bit r = 0, w = 0, x = 0;
    if (f < 3'd4) begin r = 1; w = f[0]; x = f[1]; end
    else if (f == 3'd4) x = 1;
    else if (f == 3'd5) begin r = 1; w = sup; end
    else if (sup) begin r = 1; x = 1; w = (f == 3'd7); end
    return {x, w, r};
  endfunction

  function automatic logic [2:0] model_err(input logic [2:0] f, input bit sup, input int k);
    logic [2:0] rt = model_rights(f, sup);
    bit have = (k == 1) ? rt[1] : (k == 2) ? rt[2] : rt[0];
    if (!sup && f >= 3'd6) return 3'd3;
    if (!have) return 3'd2;
    return 3'd0;
  endfunction

  function automatic logic [9:0] word(input logic [1:0] lvl, input int k, input bit sup, input logic [2:0] ft);
    return {lvl, (k == 1) ? 1'b1 : 1'b0, (k == 2) ? 1'b1 : 1'b0, sup, ft, 2'b10};
  endfunction

  function automatic logic [VA_W-1:0] align(input logic [VA_W-1:0] a);
    return (a >> PAGE_SHIFT) << PAGE_SHIFT;
  endfunction

  task automatic clear_status();
    @(negedge clk);
    reqValid = 0; statusRd = 1;
    @(negedge clk);
    statusRd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int iter;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(faultStatus == 0, "R11 status after reset", faultStatus, 0);
    check(faultAddr == 0, "R11 address after reset", faultAddr, 0);

    // sweep every kind, privilege, no-fault setting, field and modified bit
    iter = 0;
    for (int k = 0; k < 3; k++)
      for (int s = 0; s < 2; s++)
        for (int n = 0; n < 2; n++)
          for (int f = 0; f < 8; f++)
            for (int m = 0; m < 2; m++) begin
              logic [2:0] e, expMask;
              bit expOk;
              logic [9:0] expStat;
              e = model_err(f[2:0], s[0], k);
              expOk = (e == 0) || (n == 1 && s == 0);
              expMask = expOk ? (model_rights(f[2:0], s[0]) & {1'b1, m[0], 1'b1}) : 3'b000;
              expStat = expOk ? 10'd0 : word(2'd0, k, s[0], e);
              @(negedge clk);
              reqValid = 1; reqKind = k[1:0]; reqSuper = s[0]; noFaultMode = n[0];
              leafAcc = f[2:0]; leafModified = m[0];
              reqVa = 32'h1357_9000 + iter * 32'h0001_2345;
              #1;
              check(allowed == expOk, "R2 R5 allowed", allowed, expOk);
              check(permMask == expMask, "R3 R4 permMask", permMask, expMask);
              if (!expOk) expAddr = align(reqVa);
              @(negedge clk);
              reqValid = 0;
              #1;
              check(faultStatus == expStat, "R1 R2 R5 status word", faultStatus, expStat);
              check(faultAddr == expAddr, "R10 fault address", faultAddr, expAddr);
              clear_status();
              iter++;
            end

    // walk errors at every level, both types, with and without no-fault mode
    for (int l = 0; l < 4; l++)
      for (int r = 0; r < 2; r++)
        for (int n = 0; n < 2; n++) begin
          logic [9:0] expStat;
          expStat = word(l[1:0], 0, 1'b0, r ? 3'd4 : 3'd1);
          @(negedge clk);
          reqValid = 1; reqKind = 0; reqSuper = 0; noFaultMode = n[0];
          leafAcc = 3'd3; leafModified = 1; walkErr = 1;
          walkErrLevel = l[1:0]; walkErrReserved = r[0];
          reqVa = 32'hCAFE_0FFF + l * 32'h1000;
          #1;
          check(!allowed && permMask == 0, "R6 walk error denies", {allowed, permMask}, 0);
          expAddr = align(reqVa);
          @(negedge clk);
          reqValid = 0; walkErr = 0;
          #1;
          check(faultStatus == expStat, "R6 walk error status", faultStatus, expStat);
          clear_status();
        end

    // R7 overflow: two faults back to back
    @(negedge clk);
    reqValid = 1; reqKind = 1; reqSuper = 0; noFaultMode = 0; leafAcc = 3'd0; leafModified = 1;
    reqVa = 32'h0000_4123;
    @(negedge clk);
    reqKind = 2; reqSuper = 1; leafAcc = 3'd1; reqVa = 32'h0000_8456;
    @(negedge clk);
    reqValid = 0;
    #1;
    check(faultStatus == (word(2'd0, 2, 1'b1, 3'd2) | 10'd1), "R7 overflow status", faultStatus,
          word(2'd0, 2, 1'b1, 3'd2) | 10'd1);
    check(faultAddr == 32'h0000_8000, "R10 second fault address", faultAddr, 32'h0000_8000);

    // R8: value visible during read cycle, zero after
    statusRd = 1;
    #1;
    check(faultStatus != 0, "R8 visible during read", faultStatus, 1);
    @(negedge clk);
    statusRd = 0;
    #1;
    check(faultStatus == 0, "R8 cleared after read", faultStatus, 0);

    // R9: fault and read in same cycle while status nonzero
    @(negedge clk);
    reqValid = 1; reqKind = 0; reqSuper = 0; leafAcc = 3'd4; reqVa = 32'h0001_0000;
    @(negedge clk);
    leafAcc = 3'd6; statusRd = 1; reqVa = 32'h0002_0ABC;
    @(negedge clk);
    reqValid = 0; statusRd = 0;
    #1;
    check(faultStatus == word(2'd0, 0, 1'b0, 3'd3), "R9 fault with read, no overflow", faultStatus,
          word(2'd0, 0, 1'b0, 3'd3));

    // R12: idle cycles with stray inputs change nothing
    expAddr = faultAddr;
    @(negedge clk);
    reqValid = 0; walkErr = 1; leafAcc = 3'd3; reqVa = 32'hFFFF_FFFF;
    #1;
    check(!allowed && permMask == 0, "R12 idle outputs", {allowed, permMask}, 0);
    @(negedge clk);
    walkErr = 0;
    #1;
    check(faultStatus == word(2'd0, 0, 1'b0, 3'd3), "R12 status held", faultStatus,
          word(2'd0, 0, 1'b0, 3'd3));
    check(faultAddr == expAddr, "R12 address held", faultAddr, expAddr);

    finish_run();
  end
endmodule